// File: doc/BRIEF.md
# Descriptor Ring Transaction Master

This block walks a small circular ring of 16-byte transaction descriptors kept in a local descriptor store. Software writes descriptors into the store through a word-wide port and programs the ring size. It then posts work by moving a head pointer to one past the newest descriptor and setting a start bit. The block fetches the descriptor at its tail pointer and passes the descriptor fields to an external transaction engine over a request/done handshake. It writes the engine's completion status and byte counts back into the same descriptor and then advances the tail. It repeats this until the tail meets the head.

Each descriptor can ask for a completion interrupt or for processing to halt if it fails. A completion flag and an error flag in the status register drive a single interrupt line. Software clears each flag by writing one to it. The bus-level transaction is not part of this block: the engine sits outside it and is reached only through the handshake ports.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) read 0, the size register (address 2) reads 0, and `irq` is low.
- R2: Control register fields: bit 0 is the start bit, bit 4 is the error-interrupt enable, and bits 23:16 hold the head pointer. All three read back as written. The size register holds the ring entry count minus one in bits 7:0.
- R3: Status register fields: bit 0 is busy, bit 4 is the error flag, bit 5 is the completion flag, and bits 23:16 give the tail pointer.
- R4: Descriptor `n` occupies store words 4n to 4n+3. Word 0 holds the target/RW byte in bits 7:0, the write length in bits 15:8, the read length in bits 23:16 and the control byte in bits 31:24. Word 1 holds status (7:0), retry (15:8), received count (23:16) and transmitted count (31:24). Words 2 and 3 hold the low and high halves of the data pointer. Word 0 and the data pointer appear on the engine outputs while `eng_req` is high.
- R5: Descriptors are served from the tail towards the head, one at a time. `eng_req` stays high until `eng_done` is seen, and only one request is outstanding at any time.
- R6: On completion, word 1 of the descriptor is rewritten with the engine's status, received count and transmitted count, and its retry byte is kept. This write happens before the tail advances.
- R7: The tail wraps to 0 after it reaches the value in the size register. With a size value of 1 the tail alternates between 0 and 1.
- R8: A descriptor with control bit 6 set raises the completion flag when it finishes, unless it halts on error. `irq` is high while either flag is set. Writing 1 to a flag's bit clears it.
- R9: A descriptor with control bit 7 set that returns a status with bit 0 clear halts processing. The tail still advances past it, the start bit is cleared, no further request is issued, and the error flag is set if the error-interrupt enable is 1.
- R10: With the error-interrupt enable at 0 a halt leaves the error flag clear. A failing descriptor without control bit 7 does not halt, and the next pending descriptor is served.
- R11: Busy stays high without a gap from the fetch of the first pending descriptor until the tail equals the head.
- R12: Writing the control register with the start bit at 0 issues no request and leaves the tail unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 size |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_wr | input | 1 | Descriptor store write strobe |
| mem_addr | input | MEM_AW | Descriptor store word address |
| mem_wdata | input | 32 | Descriptor store write data |
| mem_rdata | output | 32 | Descriptor store read data for `mem_addr` (combinational) |
| eng_req | output | 1 | Request to the transaction engine |
| eng_tgt | output | 8 | Target address and RW bit of the current descriptor |
| eng_wlen | output | 8 | Write length or command byte |
| eng_rlen | output | 8 | Read length |
| eng_ctl | output | 8 | Descriptor control byte |
| eng_dptr | output | 64 | Data pointer |
| eng_done | input | 1 | Engine completion, valid while `eng_req` is high |
| eng_sts | input | 8 | Completion status, bit 0 means success |
| eng_rxcnt | input | 8 | Bytes received |
| eng_txcnt | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt, high while a flag is set |

## Verification
A tail pointer that is wrong shows up as a request carrying another descriptor's target byte. It also shows up as a tail field in the status register that disagrees with the count of completed handshakes, and both are visible on the next request or within four cycles of the last `eng_done`. A write-back that goes wrong shows when descriptor word 1 is read back: the retry byte is altered, or the status lands in another entry. A halt or flag that goes wrong shows in three ways: a request appears after a stop-on-error failure, the start bit is still set, or `irq` follows the enable wrongly. The bench watches the request line for twenty cycles after a halt to catch this.

// File: rtl/ring_pkg.sv
// Shared constants and types for the descriptor ring master.
// Assumes 32-bit register and store words, four words per descriptor.
package ring_pkg;
    localparam int REG_CTRL = 0;
    localparam int REG_STAT = 1;
    localparam int REG_SIZE = 2;

    localparam int CT_START = 0;   // control: start bit
    localparam int CT_EIE   = 4;   // control: error interrupt enable
    localparam int PTR_LSB  = 16;  // control/status: pointer field
    localparam int ST_BUSY  = 0;   // status: busy
    localparam int ST_ERR   = 4;   // status: error flag
    localparam int ST_DONE  = 5;   // status: completion flag

    localparam int DC_IRQ   = 6;   // descriptor control: interrupt on completion
    localparam int DC_HALT  = 7;   // descriptor control: stop on error
    localparam int DS_OK    = 0;   // descriptor status: success

    localparam int WORDS_PER_DESC = 4;

    typedef enum logic [2:0] {
        W_IDLE, W_FETCH, W_REQ, W_WB, W_ADV
    } walk_t;

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] rlen;
        logic [7:0] wlen;
        logic [7:0] tgt;
    } dhead_t;
endpackage

// File: rtl/desc_store.sv
// Local descriptor store: word-wide software port plus a walker port that
// reads a whole descriptor at once and rewrites its result word.
// Assumes software does not write an entry the walker is currently serving.
module desc_store #(
    parameter int ENTRIES = 8,
    parameter int DW      = 32,
    localparam int WORDS  = ENTRIES * ring_pkg::WORDS_PER_DESC,
    localparam int AW     = $clog2(WORDS),
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              sw_we,
    input  logic [AW-1:0]     sw_addr,
    input  logic [DW-1:0]     sw_wdata,
    output logic [DW-1:0]     sw_rdata,
    input  logic [IW-1:0]     hw_idx,
    input  logic              hw_we,
    input  logic [DW-1:0]     hw_wdata,
    output logic [4*DW-1:0]   hw_rd
);
    logic [DW-1:0] mem [WORDS];

    // Store writes; the walker's result write lands last.
    always_ff @(posedge clk) begin
        if (sw_we) mem[sw_addr] <= sw_wdata;
        if (hw_we) mem[{hw_idx, 2'b01}] <= hw_wdata;
    end

    assign sw_rdata = mem[sw_addr];

    // Present all four words of the selected descriptor.
    for (genvar k = 0; k < ring_pkg::WORDS_PER_DESC; k++) begin : g_word
        assign hw_rd[k*DW +: DW] = mem[{hw_idx, 2'(k)}];
    end
endmodule

// File: rtl/ring_regs.sv
// Register file: control (start, error enable, head), write-one-to-clear
// status flags, ring size. Walker pulses take priority over software writes.
module ring_regs #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [1:0]    addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    output logic          start,
    output logic          eie,
    output logic [PW-1:0] head,
    output logic [PW-1:0] size,
    output logic          flag_done,
    output logic          flag_err,
    input  logic [PW-1:0] tail,
    input  logic          busy,
    input  logic          set_done,
    input  logic          set_err,
    input  logic          clr_start,
    output logic          irq
);
    import ring_pkg::*;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:PTR_LSB+PW], wdata[PTR_LSB-1:6], wdata[3:1]};

    // Control register: software write, then walker halt clears start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start <= 1'b0;
            eie   <= 1'b0;
            head  <= '0;
        end else begin
            if (wr && addr == 2'(REG_CTRL)) begin
                start <= wdata[CT_START];
                eie   <= wdata[CT_EIE];
                head  <= wdata[PTR_LSB +: PW];
            end
            if (clr_start) start <= 1'b0;
        end
    end

    // Size register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           size <= '0;
        else if (wr && addr == 2'(REG_SIZE))  size <= wdata[PW-1:0];
    end

    // Status flags: write one clears, a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_done <= 1'b0;
            flag_err  <= 1'b0;
        end else begin
            if (wr && addr == 2'(REG_STAT)) begin
                if (wdata[ST_DONE]) flag_done <= 1'b0;
                if (wdata[ST_ERR])  flag_err  <= 1'b0;
            end
            if (set_done) flag_done <= 1'b1;
            if (set_err)  flag_err  <= 1'b1;
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            2'(REG_CTRL): begin
                rdata[CT_START]         = start;
                rdata[CT_EIE]           = eie;
                rdata[PTR_LSB +: PW]    = head;
            end
            2'(REG_STAT): begin
                rdata[ST_BUSY]          = busy;
                rdata[ST_ERR]           = flag_err;
                rdata[ST_DONE]          = flag_done;
                rdata[PTR_LSB +: PW]    = tail;
            end
            2'(REG_SIZE): rdata[PW-1:0] = size;
            default:      rdata         = '0;
        endcase
    end

    assign irq = flag_done | flag_err;
endmodule

// File: rtl/ring_walker.sv
// Ring walker: fetches the descriptor at the tail, runs the engine handshake,
// writes the result word back, then advances the tail modulo size+1.
// Assumes size+1 does not exceed the store's entry count.
module ring_walker #(
    parameter int ENTRIES = 8,
    parameter int PW      = 8,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          eie,
    input  logic [PW-1:0] head,
    input  logic [PW-1:0] size,
    output logic [PW-1:0] tail,
    output logic          busy,
    output logic          set_done,
    output logic          set_err,
    output logic          clr_start,
    output logic [IW-1:0] mem_idx,
    input  logic [127:0]  mem_rd,
    output logic          mem_we,
    output logic [31:0]   mem_wdata,
    output logic          eng_req,
    output logic [7:0]    eng_tgt,
    output logic [7:0]    eng_wlen,
    output logic [7:0]    eng_rlen,
    output logic [7:0]    eng_ctl,
    output logic [63:0]   eng_dptr,
    input  logic          eng_done,
    input  logic [7:0]    eng_sts,
    input  logic [7:0]    eng_rxcnt,
    input  logic [7:0]    eng_txcnt
);
    import ring_pkg::*;

    walk_t          state;
    dhead_t         cur;
    logic [7:0]     retry_q, sts_q, rx_q, tx_q;
    logic [63:0]    dptr_q;
    logic [PW-1:0]  next_tail;
    logic           halt;
    logic           unused_rd;

    assign unused_rd = ^{mem_rd[39:32], mem_rd[63:48]};

    assign next_tail = (tail == size) ? '0 : tail + 1'b1;
    assign halt      = cur.ctl[DC_HALT] && !sts_q[DS_OK];
    assign mem_idx   = tail[IW-1:0];

    // Sequencer and captured descriptor state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= W_IDLE;
            tail    <= '0;
            cur     <= '0;
            retry_q <= '0;
            sts_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            dptr_q  <= '0;
        end else begin
            case (state)
                W_IDLE: if (start && tail != head) state <= W_FETCH;
                W_FETCH: begin
                    cur     <= mem_rd[31:0];
                    retry_q <= mem_rd[47:40];
                    dptr_q  <= mem_rd[127:64];
                    state   <= W_REQ;
                end
                W_REQ: if (eng_done) begin
                    sts_q <= eng_sts;
                    rx_q  <= eng_rxcnt;
                    tx_q  <= eng_txcnt;
                    state <= W_WB;
                end
                W_WB: state <= W_ADV;
                W_ADV: begin
                    tail <= next_tail;
                    if (!halt && start && next_tail != head) state <= W_FETCH;
                    else                                     state <= W_IDLE;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // Handshake, write-back and flag pulses decoded from the state.
    always_comb begin
        busy      = (state != W_IDLE);
        eng_req   = (state == W_REQ);
        mem_we    = (state == W_WB);
        mem_wdata = {tx_q, rx_q, retry_q, sts_q};
        set_done  = (state == W_ADV) && cur.ctl[DC_IRQ] && !halt;
        set_err   = (state == W_ADV) && halt && eie;
        clr_start = (state == W_ADV) && halt;
    end

    assign eng_tgt  = cur.tgt;
    assign eng_wlen = cur.wlen;
    assign eng_rlen = cur.rlen;
    assign eng_ctl  = cur.ctl;
    assign eng_dptr = dptr_q;
endmodule

// File: rtl/desc_ring_ctrl.sv
// Top of the descriptor ring master: register file, descriptor store and
// ring walker. The transaction engine is external, on the eng_* handshake.
module desc_ring_ctrl #(
    parameter int ENTRIES = 8,
    localparam int PW     = 8,
    localparam int MEM_AW = $clog2(ENTRIES * ring_pkg::WORDS_PER_DESC),
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mem_wr,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic [31:0]       mem_wdata,
    output logic [31:0]       mem_rdata,
    output logic              eng_req,
    output logic [7:0]        eng_tgt,
    output logic [7:0]        eng_wlen,
    output logic [7:0]        eng_rlen,
    output logic [7:0]        eng_ctl,
    output logic [63:0]       eng_dptr,
    input  logic              eng_done,
    input  logic [7:0]        eng_sts,
    input  logic [7:0]        eng_rxcnt,
    input  logic [7:0]        eng_txcnt,
    output logic              irq
);
    logic          start_w, eie_w, busy_w;
    logic          flag_done_w, flag_err_w;
    logic          set_done_w, set_err_w, clr_start_w;
    logic [PW-1:0] head_w, size_w, tail_w;
    logic [IW-1:0] idx_w;
    logic [127:0]  desc_w;
    logic          mem_we_w;
    logic [31:0]   wb_w;

    ring_regs #(.PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .start(start_w), .eie(eie_w), .head(head_w), .size(size_w),
        .flag_done(flag_done_w), .flag_err(flag_err_w),
        .tail(tail_w), .busy(busy_w),
        .set_done(set_done_w), .set_err(set_err_w), .clr_start(clr_start_w),
        .irq(irq)
    );

    desc_store #(.ENTRIES(ENTRIES), .DW(32)) u_store (
        .clk(clk), .sw_we(mem_wr), .sw_addr(mem_addr),
        .sw_wdata(mem_wdata), .sw_rdata(mem_rdata),
        .hw_idx(idx_w), .hw_we(mem_we_w), .hw_wdata(wb_w), .hw_rd(desc_w)
    );

    ring_walker #(.ENTRIES(ENTRIES), .PW(PW)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start_w), .eie(eie_w),
        .head(head_w), .size(size_w), .tail(tail_w), .busy(busy_w),
        .set_done(set_done_w), .set_err(set_err_w), .clr_start(clr_start_w),
        .mem_idx(idx_w), .mem_rd(desc_w), .mem_we(mem_we_w), .mem_wdata(wb_w),
        .eng_req(eng_req), .eng_tgt(eng_tgt), .eng_wlen(eng_wlen),
        .eng_rlen(eng_rlen), .eng_ctl(eng_ctl), .eng_dptr(eng_dptr),
        .eng_done(eng_done), .eng_sts(eng_sts),
        .eng_rxcnt(eng_rxcnt), .eng_txcnt(eng_txcnt)
    );
endmodule

// File: rtl/ring_chk.sv
// Checker for the descriptor ring master, bound to the top module.
// Assumes software does not move the head while a run is finishing.
module ring_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          eng_req,
    input logic          eng_done,
    input logic          busy,
    input logic          start,
    input logic          eie,
    input logic          flag_err,
    input logic          set_done,
    input logic          set_err,
    input logic          mem_we,
    input logic          irq,
    input logic [PW-1:0] tail,
    input logic [PW-1:0] head
);
    // R5: a request is held until the engine answers.
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req);

    // R5: a request only appears while the walker reports busy.
    a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> busy);

    // R6: the tail moves only after a result write two cycles earlier.
    a_r6_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (tail != $past(tail)) |-> $past(mem_we, 2));

    // R8: the interrupt line rises only after a flag set pulse.
    a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(set_done || set_err));

    // R10: the error flag never rises with the enable off.
    a_r10_err_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_err) |-> $past(eie));

    // R11: busy drops only once the ring is drained or the run was stopped.
    a_r11_drained: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (tail == head) || !start);
endmodule

bind desc_ring_ctrl ring_chk #(.PW(8)) u_chk (
    .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_done(eng_done),
    .busy(busy_w), .start(start_w), .eie(eie_w), .flag_err(flag_err_w),
    .set_done(set_done_w), .set_err(set_err_w), .mem_we(mem_we_w),
    .irq(irq), .tail(tail_w), .head(head_w)
);

// File: tb/sim_desc_ring_ctrl.sv
// Directed bench for desc_ring_ctrl; the bench plays the transaction engine.
module sim_desc_ring_ctrl;
    localparam int ENT = 8;
    localparam int AW  = $clog2(ENT * 4);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd1;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          mem_wr = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [31:0]   mem_wdata = '0;
    logic [31:0]   mem_rdata;
    logic          eng_req;
    logic [7:0]    eng_tgt, eng_wlen, eng_rlen, eng_ctl;
    logic [63:0]   eng_dptr;
    logic          eng_done = 1'b0;
    logic [7:0]    eng_sts = '0, eng_rxcnt = '0, eng_txcnt = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit watch = 0;
    bit dropped = 0;
    logic [63:0] seen_dptr;
    logic [7:0]  seen_wlen, seen_rlen;

    always #5 clk = ~clk;

    desc_ring_ctrl #(.ENTRIES(ENT)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .eng_req(eng_req), .eng_tgt(eng_tgt), .eng_wlen(eng_wlen),
        .eng_rlen(eng_rlen), .eng_ctl(eng_ctl), .eng_dptr(eng_dptr),
        .eng_done(eng_done), .eng_sts(eng_sts), .eng_rxcnt(eng_rxcnt),
        .eng_txcnt(eng_txcnt), .irq(irq)
    );

    // Busy-gap monitor for R11 (reg_addr rests on the status register).
    always @(negedge clk) if (watch && reg_addr == 2'd1 && !reg_rdata[0]) dropped = 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata; reg_addr = 2'd1;
    endtask

    task automatic mem_write(input int a, input logic [31:0] d);
        @(negedge clk); mem_wr = 1'b1; mem_addr = AW'(a); mem_wdata = d;
        @(negedge clk); mem_wr = 1'b0;
    endtask

    task automatic mem_read(input int a, output logic [31:0] d);
        @(negedge clk); mem_addr = AW'(a); #1 d = mem_rdata;
    endtask

    task automatic load(input int idx, input logic [7:0] tgt, wlen, rlen, ctl, retry,
                        input logic [31:0] dlo, dhi);
        mem_write(idx*4,   {ctl, rlen, wlen, tgt});
        mem_write(idx*4+1, {8'h00, 8'h00, retry, 8'h00});
        mem_write(idx*4+2, dlo);
        mem_write(idx*4+3, dhi);
    endtask

    task automatic post(input logic [7:0] head, input bit eie);
        reg_write(2'd0, {8'h00, head, 11'h0, eie, 3'h0, 1'b1});
    endtask

    // Engine model: wait for a request, check it, answer for one cycle.
    task automatic serve(input logic [7:0] exp_tgt, exp_ctl, sts, rx, tx, input string req);
        int n = 0;
        @(negedge clk);
        while (!eng_req && n < 60) begin @(negedge clk); n++; end
        check(eng_req === 1'b1, req, {63'h0, eng_req}, 64'h1);
        check(eng_tgt === exp_tgt, req, {56'h0, eng_tgt}, {56'h0, exp_tgt});
        check(eng_ctl === exp_ctl, req, {56'h0, eng_ctl}, {56'h0, exp_ctl});
        seen_dptr = eng_dptr; seen_wlen = eng_wlen; seen_rlen = eng_rlen;
        eng_done = 1'b1; eng_sts = sts; eng_rxcnt = rx; eng_txcnt = tx;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        reg_read(2'd0, d); check(d === 32'h0, "R1 ctrl", {32'h0, d}, 64'h0);
        reg_read(2'd1, d); check(d === 32'h0, "R1 status", {32'h0, d}, 64'h0);
        reg_read(2'd2, d); check(d === 32'h0, "R1 size", {32'h0, d}, 64'h0);
        check(irq === 1'b0, "R1 irq", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bit saw = 0;
        reg_write(2'd2, 32'h3);
        reg_read(2'd2, d); check(d === 32'h3, "R2 size", {32'h0, d}, 64'h3);
        reg_write(2'd0, 32'h0005_0010);
        reg_read(2'd0, d); check(d === 32'h0005_0010, "R2 ctrl", {32'h0, d}, 64'h50010);
        repeat (10) begin @(negedge clk); if (eng_req) saw = 1; end
        check(!saw, "R12 no request", {63'h0, saw}, 64'h0);
        reg_read(2'd1, d); check(d === 32'h0, "R12 tail held", {32'h0, d}, 64'h0);
        reg_write(2'd0, 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        load(0, 8'hA1, 8'h02, 8'h00, 8'h00, 8'h33, 32'h1000_0040, 32'h0000_0001);
        load(1, 8'h50, 8'h05, 8'h02, 8'h00, 8'h11, 32'h0, 32'h0);
        load(2, 8'hC3, 8'h07, 8'h01, 8'h40, 8'h22, 32'h0, 32'h0);
        post(8'd3, 1'b0);
        serve(8'hA1, 8'h00, 8'h01, 8'h00, 8'h03, "R5 entry0");
        check(seen_dptr === 64'h0000_0001_1000_0040, "R4 dptr", seen_dptr, 64'h0000_0001_1000_0040);
        check({seen_wlen, seen_rlen} === 16'h0200, "R4 lengths", {48'h0, seen_wlen, seen_rlen}, 64'h0200);
        dropped = 0; watch = 1;
        serve(8'h50, 8'h00, 8'h01, 8'h02, 8'h01, "R5 entry1");
        check({seen_wlen, seen_rlen} === 16'h0502, "R4 lengths e1", {48'h0, seen_wlen, seen_rlen}, 64'h0502);
        serve(8'hC3, 8'h40, 8'h01, 8'h01, 8'h01, "R5 entry2");
        watch = 0;
        check(!dropped, "R11 busy held", {63'h0, dropped}, 64'h0);
        settle();
        reg_read(2'd1, d); check(d === 32'h0003_0020, "R3 status", {32'h0, d}, 64'h30020);
        check(irq === 1'b1, "R8 irq set", {63'h0, irq}, 64'h1);
        mem_read(1, d); check(d === 32'h0300_3301, "R6 word1 e0", {32'h0, d}, 64'h03003301);
        mem_read(5, d); check(d === 32'h0102_1101, "R6 word1 e1", {32'h0, d}, 64'h01021101);
        mem_read(9, d); check(d === 32'h0101_2201, "R6 word1 e2", {32'h0, d}, 64'h01012201);
        reg_write(2'd1, 32'h20);
        check(irq === 1'b0, "R8 w1c irq", {63'h0, irq}, 64'h0);
        reg_read(2'd1, d); check(d === 32'h0003_0000, "R8 w1c status", {32'h0, d}, 64'h30000);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        do_reset();
        reg_write(2'd2, 32'h1);
        load(0, 8'h10, 8'h01, 8'h00, 8'h00, 8'h00, 32'h0, 32'h0);
        load(1, 8'h20, 8'h01, 8'h00, 8'h00, 8'h00, 32'h0, 32'h0);
        post(8'd1, 1'b0);
        serve(8'h10, 8'h00, 8'h01, 8'h00, 8'h01, "R7 first");
        settle(); reg_read(2'd1, d); check(d[23:16] === 8'd1, "R7 tail 1", {56'h0, d[23:16]}, 64'h1);
        post(8'd0, 1'b0);
        serve(8'h20, 8'h00, 8'h01, 8'h00, 8'h01, "R7 second");
        settle(); reg_read(2'd1, d); check(d[23:16] === 8'd0, "R7 tail wraps", {56'h0, d[23:16]}, 64'h0);
        post(8'd1, 1'b0);
        serve(8'h10, 8'h00, 8'h01, 8'h00, 8'h01, "R7 third");
        settle(); reg_read(2'd1, d); check(d[23:16] === 8'd1, "R7 tail again", {56'h0, d[23:16]}, 64'h1);
    endtask

    task automatic t_halt();
        logic [31:0] d;
        bit saw = 0;
        do_reset();
        reg_write(2'd2, 32'h3);
        load(0, 8'h30, 8'h01, 8'h00, 8'h80, 8'h44, 32'h0, 32'h0);
        load(1, 8'h31, 8'h01, 8'h00, 8'h00, 8'h00, 32'h0, 32'h0);
        post(8'd2, 1'b1);
        serve(8'h30, 8'h80, 8'h08, 8'h00, 8'h01, "R9 failing entry");
        repeat (20) begin @(negedge clk); if (eng_req) saw = 1; end
        check(!saw, "R9 no further request", {63'h0, saw}, 64'h0);
        reg_read(2'd0, d); check(d === 32'h0002_0010, "R9 start cleared", {32'h0, d}, 64'h20010);
        reg_read(2'd1, d); check(d === 32'h0001_0010, "R9 error flag", {32'h0, d}, 64'h10010);
        check(irq === 1'b1, "R9 irq", {63'h0, irq}, 64'h1);
        mem_read(1, d); check(d === 32'h0100_4408, "R6 halt write-back", {32'h0, d}, 64'h01004408);
        reg_write(2'd1, 32'h10);
        check(irq === 1'b0, "R8 w1c error", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_no_enable();
        logic [31:0] d;
        do_reset();
        reg_write(2'd2, 32'h3);
        load(0, 8'h40, 8'h01, 8'h00, 8'h80, 8'h00, 32'h0, 32'h0);
        load(1, 8'h41, 8'h01, 8'h00, 8'h40, 8'h00, 32'h0, 32'h0);
        load(2, 8'h42, 8'h01, 8'h00, 8'h00, 8'h00, 32'h0, 32'h0);
        post(8'd1, 1'b0);
        serve(8'h40, 8'h80, 8'h04, 8'h00, 8'h00, "R10 halt no enable");
        settle();
        reg_read(2'd1, d); check(d === 32'h0001_0000, "R10 flag stays clear", {32'h0, d}, 64'h10000);
        check(irq === 1'b0, "R10 irq low", {63'h0, irq}, 64'h0);
        reg_read(2'd0, d); check(d === 32'h0001_0000, "R9 start cleared no enable", {32'h0, d}, 64'h10000);
        post(8'd3, 1'b0);
        serve(8'h41, 8'h40, 8'h10, 8'h00, 8'h00, "R10 error without halt");
        serve(8'h42, 8'h00, 8'h01, 8'h00, 8'h01, "R10 next entry served");
        settle();
        reg_read(2'd1, d); check(d === 32'h0003_0020, "R10 continued", {32'h0, d}, 64'h30020);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        t_reset();
        t_regs();
        t_basic();
        t_wrap();
        t_halt();
        t_no_enable();
        summary();
    end
endmodule